// File: doc/BRIEF.md
# Match-Reload Timer with Cross-Domain Count Snapshot

This block is a timer with one up-counter that runs on a slow counting clock, `tclk_i`. That clock is asynchronous to the bus clock `clk_i`, which drives a simple word-addressed register port. The counter has three compare registers. When the count equals a compare value, a status flag is set in the bus domain. If the matching enable is also set, the flag raises `irq_o`. A select register picks one of the comparators (or none). When the selected comparator hits, the next count is the preload value instead of count + 1. This makes a periodic counter between the preload and the selected compare value.

Software does not read the live count directly. It writes 1 to the snapshot register. That request crosses into the counting domain on a toggle. The count is captured there and returned with a done toggle. A later read of the same register gives the captured value. Until the new capture arrives, the register keeps its previous contents.

Top module: `snap_timer`

## Requirements
- R1: While counting is enabled, the count rises by one on each `tclk_i` rising edge. After 2^CNT_W-1 it wraps to 0 unless a reload applies.
- R2: When the reload select (address 2) holds k+1 and the count equals compare k (address 8+k), the next count is the preload value (address 1).
- R3: Bit 0 of the control register (address 0) enables counting. While it is 0, the count holds its value.
- R4: Writing 1 to bit 0 of the snapshot register (address 3) captures the live count. Reads of address 3 return the last captured value, and that value is unchanged in the cycle after the request.
- R5: Status bit k (address 4) is set when the count equals compare k while counting is enabled. Writing 1 to bit k clears it, and bits written 0 are left alone.
- R6: `irq_o` is 1 exactly when some status bit and the same bit of the interrupt enable register (address 5) are both 1.
- R7: After reset, the count, status, snapshot and all configuration registers are 0, and `irq_o` is 0.
- R8: A reload select of 0 disables reloading, so the counter runs freely through every compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tclk_i | input | 1 | Counting clock, asynchronous to clk_i |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench builds the timer with an 8-bit counter (CNT_W = 8). This puts the wrap from 255 to 0 and the compare value 0xFF within a few hundred counting clocks, so the free-running and wrap behaviour can be seen directly. For the table-driven part, the counter is stopped before each snapshot. This makes the captured value stable, and each reload select can then be checked against a known window of values.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PRE  = 1;
  localparam int ADDR_SEL  = 2;
  localparam int ADDR_SNAP = 3;
  localparam int ADDR_STAT = 4;
  localparam int ADDR_IEN  = 5;
  localparam int ADDR_M0   = 8;
endpackage

// File: rtl/tog_sync.sv
module tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], tog_i};
  end

  assign lvl_o = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 3,
  parameter int STAGES    = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [CNT_W-1:0]     pre_i,
  input  logic [CNT_W-1:0]     match_i [NUM_MATCH],
  input  logic                 req_tog_i,
  output logic [NUM_MATCH-1:0] hit_tog_o,
  output logic                 done_tog_o,
  output logic [CNT_W-1:0]     cap_o
);
  logic en_s, req_s, req_d;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_MATCH-1:0] hit;
  logic reload;

  tog_sync #(.STAGES(STAGES)) u_en_sync  (.clk_i(clk_i), .rst_ni(rst_ni), .tog_i(en_i),      .lvl_o(en_s));
  tog_sync #(.STAGES(STAGES)) u_req_sync (.clk_i(clk_i), .rst_ni(rst_ni), .tog_i(req_tog_i), .lvl_o(req_s));

  always_comb begin
    reload = 1'b0;
    for (int k = 0; k < NUM_MATCH; k++) begin
      hit[k] = en_s && (cnt_q == match_i[k]);
      if (sel_i == SEL_W'(k + 1) && hit[k]) reload = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      hit_tog_o  <= '0;
      req_d      <= 1'b0;
      done_tog_o <= 1'b0;
      cap_o      <= '0;
    end else begin
      if (en_s) cnt_q <= reload ? pre_i : cnt_q + 1'b1;
      hit_tog_o <= hit_tog_o ^ hit;
      req_d     <= req_s;
      if (req_s ^ req_d) begin
        cap_o      <= cnt_q;
        done_tog_o <= ~done_tog_o;
      end
    end
  end

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && !reload) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && reload) |=> cnt_q == $past(pre_i));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> $stable(cnt_q));
endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 3,
  parameter int ADDR_W    = 4,
  parameter int STAGES    = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic                 en_q, req_tog_q;
  logic [SEL_W-1:0]     sel_q;
  logic [CNT_W-1:0]     pre_q, snap_q;
  logic [CNT_W-1:0]     match_q [NUM_MATCH];
  logic [NUM_MATCH-1:0] stat_q, ien_q, hit_set;
  logic [NUM_MATCH-1:0] hit_tog, hit_s, hit_d;
  logic                 done_tog, done_s, done_d;
  logic [CNT_W-1:0]     cap;
  logic                 wr, wr_snap, wr_stat;

  assign wr      = req_i && we_i;
  assign wr_snap = wr && addr_i == ADDR_W'(ADDR_SNAP) && wdata_i[0];
  assign wr_stat = wr && addr_i == ADDR_W'(ADDR_STAT);

  tmr_core #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .STAGES(STAGES)) u_core (
    .clk_i(tclk_i), .rst_ni(rst_ni), .en_i(en_q), .sel_i(sel_q), .pre_i(pre_q),
    .match_i(match_q), .req_tog_i(req_tog_q), .hit_tog_o(hit_tog),
    .done_tog_o(done_tog), .cap_o(cap));

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_hit
    tog_sync #(.STAGES(STAGES)) u_hit_sync (.clk_i(clk_i), .rst_ni(rst_ni),
      .tog_i(hit_tog[k]), .lvl_o(hit_s[k]));
  end
  tog_sync #(.STAGES(STAGES)) u_done_sync (.clk_i(clk_i), .rst_ni(rst_ni),
    .tog_i(done_tog), .lvl_o(done_s));

  assign hit_set = hit_s ^ hit_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      sel_q     <= '0;
      pre_q     <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
      snap_q    <= '0;
      req_tog_q <= 1'b0;
      hit_d     <= '0;
      done_d    <= 1'b0;
      for (int k = 0; k < NUM_MATCH; k++) match_q[k] <= '0;
    end else begin
      hit_d  <= hit_s;
      done_d <= done_s;
      if (done_s ^ done_d) snap_q <= cap; // cap stable since its done toggle
      if (wr_snap) req_tog_q <= ~req_tog_q;
      // set wins over a simultaneous clear
      stat_q <= (stat_q & ~(wr_stat ? wdata_i[NUM_MATCH-1:0] : '0)) | hit_set;
      if (wr) begin
        if (addr_i == ADDR_W'(ADDR_CTRL)) en_q  <= wdata_i[0];
        if (addr_i == ADDR_W'(ADDR_PRE))  pre_q <= wdata_i[CNT_W-1:0];
        if (addr_i == ADDR_W'(ADDR_SEL))  sel_q <= wdata_i[SEL_W-1:0];
        if (addr_i == ADDR_W'(ADDR_IEN))  ien_q <= wdata_i[NUM_MATCH-1:0];
        for (int k = 0; k < NUM_MATCH; k++)
          if (addr_i == ADDR_W'(ADDR_M0 + k)) match_q[k] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o = 32'(en_q);
    else if (addr_i == ADDR_W'(ADDR_PRE))  rdata_o = 32'(pre_q);
    else if (addr_i == ADDR_W'(ADDR_SEL))  rdata_o = 32'(sel_q);
    else if (addr_i == ADDR_W'(ADDR_SNAP)) rdata_o = 32'(snap_q);
    else if (addr_i == ADDR_W'(ADDR_STAT)) rdata_o = 32'(stat_q);
    else if (addr_i == ADDR_W'(ADDR_IEN))  rdata_o = 32'(ien_q);
    for (int k = 0; k < NUM_MATCH; k++)
      if (addr_i == ADDR_W'(ADDR_M0 + k)) rdata_o = 32'(match_q[k]);
  end

  assign irq_o = |(stat_q & ien_q);

  p_snap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_snap |=> $stable(snap_q));
  p_w1c_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_q) & ~stat_q)) |-> $past(wr_stat));
  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (|ien_q));
  p_stat_from_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & ~$past(stat_q))) |-> $past(|hit_set));
endmodule

// File: tb/snap_timer_tb.sv
module snap_timer_tb;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 4;

  logic clk = 0, tclk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #4  clk  = ~clk;
  always #15 tclk = ~tclk;

  snap_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // {sel, pre, m0, m1, m2, lo, hi, status}
  localparam logic [52:0] VEC [4] = '{
    {2'd1, 8'd2,  8'd5,   8'd200, 8'd201, 8'd2,  8'd5,  3'b001},
    {2'd2, 8'd10, 8'd15,  8'd20,  8'd250, 8'd10, 8'd20, 3'b011},
    {2'd3, 8'd0,  8'd3,   8'd9,   8'd7,   8'd0,  8'd7,  3'b101},
    {2'd0, 8'd0,  8'd255, 8'd64,  8'd254, 8'd30, 8'd60, 3'b111}
  };

  task automatic wr(input int a, input int d);
    @(negedge clk); req = 1; we = 1; addr = ADDR_W'(a); wdata = 32'(d);
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = ADDR_W'(a); #1 d = rdata;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic chk_rng(input string r, input logic [31:0] act, input int lo, input int hi);
    n_run++;
    if (int'(act) < lo || int'(act) > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=[%0d,%0d]", r, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(posedge tclk); rst_n = 1; repeat (2) @(posedge clk);
  endtask

  task automatic snap(output logic [31:0] d);
    wr(3, 1); repeat (30) @(posedge clk); rd(3, d);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    do_reset();
    // R7: reset state
    rd(4, v); chk("R7 status", v, 0);
    rd(3, v); chk("R7 snapshot", v, 0);
    rd(2, v); chk("R7 select", v, 0);
    chk("R7 irq", 32'(irq), 0);
    snap(v); chk("R7 count", v, 0);

    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(2, VEC[i][52:51]); wr(1, VEC[i][50:43]);
      wr(8, VEC[i][42:35]); wr(9, VEC[i][34:27]); wr(10, VEC[i][26:19]);
      wr(0, 1);
      repeat (300) @(posedge tclk);
      wr(0, 0);
      repeat (10) @(posedge tclk);
      if (i == 0) begin
        wr(3, 1); rd(3, v); chk("R4 hold old", v, 0);
        repeat (30) @(posedge clk); rd(3, v);
      end else snap(v);
      chk_rng(i == 3 ? "R1 R8 wrap" : "R2 reload window", v, VEC[i][18:11], VEC[i][10:3]);
      rd(4, v2); chk("R5 status", v2, 32'(VEC[i][2:0]));
    end

    // R3: stopped counter holds across time
    snap(v); repeat (50) @(posedge tclk); snap(v2); chk("R3 hold", v2, v);
    // R6: irq gating
    wr(5, 0); @(negedge clk); chk("R6 irq masked", 32'(irq), 0);
    wr(5, 3'b010); @(negedge clk); chk("R6 irq on", 32'(irq), 1);
    // R5: write-1-to-clear, other bits untouched
    wr(4, 3'b010); rd(4, v); chk("R5 w1c", v, 3'b101);
    @(negedge clk); chk("R6 irq off", 32'(irq), 0);
    wr(5, 3'b100); @(negedge clk); chk("R6 irq bit2", 32'(irq), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule